// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Fine Rate Trim

This block is a free-running time-of-day counter for precision time protocol work. It holds a 32-bit seconds count, a 32-bit nanoseconds count and a 32-bit sub-nanosecond residue. On every clock cycle it adds a nominal 8 ns step. A signed fine-rate correction is applied on top of that step. The correction is summed into the residue, and each carry out of the residue adds one nanosecond, while each borrow removes one.

Software reaches the clock through a plain strobe-based register port. The port has separate write and read strobes, and each strobe has its own address. Reading the residue word freezes a copy of the whole time value. The nanoseconds and seconds reads that follow return that copy, so a multi-word read is coherent. Software sets the time in two writes: nanoseconds first, then seconds. The seconds write commits both values at once. The live seconds and nanoseconds are also driven out as ports, together with a single-cycle pulse for the seconds rollover.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the seconds, nanoseconds, residue and adjust word are all zero, and `sec_wrap` is low.
- R2: When the adjust word is zero, the nanoseconds value grows by exactly 8 in every cycle and the residue does not change.
- R3: When adjust bit 31 is clear, the magnitude in bits 30:0 is added to the 32-bit residue every cycle. A carry out of the residue makes that cycle's step 9 ns.
- R4: When adjust bit 31 is set, the magnitude is subtracted from the residue every cycle. A borrow out of the residue makes that cycle's step 7 ns.
- R5: When a step brings nanoseconds to 1,000,000,000 or above, 1,000,000,000 is subtracted from it and seconds grow by one in the same cycle. Nanoseconds always stay below 1,000,000,000.
- R6: When seconds roll over from 0xFFFFFFFF to 0 by counting, `sec_wrap` is high for exactly the one cycle in which seconds read 0.
- R7: Register addresses are: residue 0x0, nanoseconds 0x4, seconds 0x8, adjust 0xC. Read data appears on `rd_data` after the clock edge that samples `rd_en`. A residue read returns the residue and latches seconds and nanoseconds. Reads of 0x4 and 0x8 then return the latched copy, however many cycles have passed.
- R8: A write to 0x4 only holds a pending nanoseconds value. A write to 0x8 loads seconds from the write data and nanoseconds from the pending value, and clears the residue, all at the same edge. Counting resumes from the loaded value one cycle later.
- R9: A write to 0x4 with a value of 1,000,000,000 or more is ignored, and the pending value is kept.
- R10: A write to 0x0 sets the residue directly, and that value takes part in the next cycle's carry.
- R11: A write to 0xC sets the adjust word, and a read of 0xC returns it unchanged.
- R12: When a residue read and a seconds write fall at the same edge, the snapshot takes the time from before the load, and the live time takes the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Registered read data |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 32 | Live nanoseconds |
| sec_wrap | output | 1 | One-cycle seconds rollover pulse |

## Verification
The snapshot taken by a residue read and the load done by a seconds write can fall on the same clock edge. The bench provokes this by raising both strobes in the same cycle, a few cycles after a known load. Two things are judged. The snapshot must carry the older, counted time, which later seconds and nanoseconds reads show. The live ports must show the newly loaded time. The nanosecond rollover and the seconds rollover also meet in a single step. That case is provoked by loading seconds 0xFFFFFFFF with nanoseconds eight short of a full second.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
   localparam int WORD_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t sec;
      word_t ns;
      word_t frac;
   } tod_t;
endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum
   import ptp_tod_pkg::*;
#(
   parameter bit ADJ_EN = 1'b1
) (
   input  word_t frac_q,
   input  word_t adj_word,
   output word_t frac_nxt,
   output logic  carry,
   output logic  borrow
);
   localparam int MAG_W = WORD_W - 1;

   generate
      if (ADJ_EN) begin : g_trim
         logic [WORD_W:0] up_sum;
         logic [WORD_W:0] dn_sum;
         logic            slow;

         always_comb begin
            slow   = adj_word[WORD_W-1];
            up_sum = {1'b0, frac_q} + {2'b00, adj_word[MAG_W-1:0]};
            dn_sum = {1'b0, frac_q} - {2'b00, adj_word[MAG_W-1:0]};
            if (slow) begin
               frac_nxt = dn_sum[WORD_W-1:0];
               carry    = 1'b0;
               borrow   = dn_sum[WORD_W];
            end else begin
               frac_nxt = up_sum[WORD_W-1:0];
               carry    = up_sum[WORD_W];
               borrow   = 1'b0;
            end
         end
      end else begin : g_fixed
         always_comb begin
            frac_nxt = frac_q;
            carry    = 1'b0;
            borrow   = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
   import ptp_tod_pkg::*;
#(
   parameter int unsigned NOM_INC_NS = 8,
   parameter int unsigned NS_PER_SEC = 1000000000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  carry,
   input  logic  borrow,
   input  word_t frac_nxt,
   input  logic  load,
   input  word_t load_sec,
   input  word_t load_ns,
   input  logic  res_wr,
   input  word_t res_data,
   output tod_t  tod,
   output logic  sec_wrap
);
   localparam logic [WORD_W:0]   LIM33 = (WORD_W+1)'(NS_PER_SEC);
   localparam logic [WORD_W:0]   INC33 = (WORD_W+1)'(NOM_INC_NS);
   localparam logic [WORD_W-1:0] LIM32 = WORD_W'(NS_PER_SEC);
   localparam logic [WORD_W-1:0] INC32 = WORD_W'(NOM_INC_NS);

   word_t           sec_q, ns_q, frac_q;
   logic            wrap_q;
   logic [WORD_W:0] ns_sum;
   logic            roll;
   word_t           ns_d, sec_d;

   always_comb begin
      ns_sum = {1'b0, ns_q} + INC33 + {{WORD_W{1'b0}}, carry} - {{WORD_W{1'b0}}, borrow};
      roll   = (ns_sum >= LIM33);
      ns_d   = ns_q + INC32 + {{(WORD_W-1){1'b0}}, carry}
               - {{(WORD_W-1){1'b0}}, borrow} - (roll ? LIM32 : '0);
      sec_d  = sec_q + {{(WORD_W-1){1'b0}}, roll};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         ns_q   <= '0;
         frac_q <= '0;
         wrap_q <= 1'b0;
      end else if (load) begin
         sec_q  <= load_sec;
         ns_q   <= load_ns;
         frac_q <= '0;
         wrap_q <= 1'b0;
      end else begin
         sec_q  <= sec_d;
         ns_q   <= ns_d;
         frac_q <= res_wr ? res_data : frac_nxt;
         wrap_q <= roll && (&sec_q);
      end
   end

   assign tod      = '{sec: sec_q, ns: ns_q, frac: frac_q};
   assign sec_wrap = wrap_q;

   // R5: nanoseconds never reach a full second
   a_r5_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
      ns_q < LIM32);

   // R6: the pulse follows a counted rollover of seconds
   a_r6_wrap_origin: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> (sec_q == '0) && ($past(sec_q) == '1));

   // R6: the pulse lasts a single cycle
   a_r6_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> !wrap_q);

   // R2: without a load, seconds hold or step by one
   a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1));

   // R8: a load leaves the residue cleared
   a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (frac_q == '0));
endmodule

// File: rtl/ptp_reg_port.sv
module ptp_reg_port
   import ptp_tod_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned ADR_RES    = 0,
   parameter int unsigned ADR_NS     = 4,
   parameter int unsigned ADR_SEC    = 8,
   parameter int unsigned ADR_ADJ    = 12,
   parameter int unsigned NS_PER_SEC = 1000000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  word_t             wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  tod_t              live,
   output word_t             rd_data,
   output word_t             adj_word,
   output logic              load,
   output word_t             load_sec,
   output word_t             load_ns,
   output logic              res_wr,
   output word_t             res_data
);
   localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(ADR_RES);
   localparam logic [ADDR_W-1:0] A_NS  = ADDR_W'(ADR_NS);
   localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(ADR_SEC);
   localparam logic [ADDR_W-1:0] A_ADJ = ADDR_W'(ADR_ADJ);
   localparam word_t             LIM   = WORD_W'(NS_PER_SEC);

   word_t adj_q, pend_q, shd_sec_q, shd_ns_q, rdat_q;
   logic  snap;

   assign snap     = rd_en && (rd_addr == A_RES);
   assign load     = wr_en && (wr_addr == A_SEC);
   assign load_sec = wr_data;
   assign load_ns  = pend_q;
   assign res_wr   = wr_en && (wr_addr == A_RES);
   assign res_data = wr_data;
   assign adj_word = adj_q;
   assign rd_data  = rdat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q  <= '0;
         pend_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_ADJ) adj_q <= wr_data;
         if ((wr_addr == A_NS) && (wr_data < LIM)) pend_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_sec_q <= '0;
         shd_ns_q  <= '0;
      end else if (snap) begin
         shd_sec_q <= live.sec;
         shd_ns_q  <= live.ns;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (rd_en) begin
         unique case (rd_addr)
            A_RES:   rdat_q <= live.frac;
            A_NS:    rdat_q <= shd_ns_q;
            A_SEC:   rdat_q <= shd_sec_q;
            A_ADJ:   rdat_q <= adj_q;
            default: rdat_q <= '0;
         endcase
      end
   end

   // R9: the pending nanoseconds value is always a legal one
   a_r9_pend_range: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q < LIM);

   // R7: the frozen copy moves only on a residue read
   a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(shd_ns_q) && $stable(shd_sec_q));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
   import ptp_tod_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned ADR_RES    = 0,
   parameter int unsigned ADR_NS     = 4,
   parameter int unsigned ADR_SEC    = 8,
   parameter int unsigned ADR_ADJ    = 12,
   parameter int unsigned NOM_INC_NS = 8,
   parameter int unsigned NS_PER_SEC = 1000000000,
   parameter bit          ADJ_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic [31:0]       tod_sec,
   output logic [31:0]       tod_ns,
   output logic              sec_wrap
);
   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("word width must be 32");
      end
      if (ADR_RES >= ADDR_SPAN || ADR_NS >= ADDR_SPAN ||
          ADR_SEC >= ADDR_SPAN || ADR_ADJ >= ADDR_SPAN) begin : g_bad_addr
         $error("register address exceeds address width");
      end
      if (ADR_RES == ADR_NS || ADR_RES == ADR_SEC || ADR_RES == ADR_ADJ ||
          ADR_NS == ADR_SEC || ADR_NS == ADR_ADJ || ADR_SEC == ADR_ADJ) begin : g_bad_map
         $error("register addresses must be distinct");
      end
      if (NOM_INC_NS == 0 || NOM_INC_NS + 1 >= NS_PER_SEC) begin : g_bad_inc
         $error("nominal increment out of range");
      end
   endgenerate

   word_t adj_word, frac_nxt, load_sec, load_ns, res_data;
   logic  carry, borrow, load, res_wr;
   tod_t  tod;

   ptp_reg_port #(
      .ADDR_W(ADDR_W), .ADR_RES(ADR_RES), .ADR_NS(ADR_NS),
      .ADR_SEC(ADR_SEC), .ADR_ADJ(ADR_ADJ), .NS_PER_SEC(NS_PER_SEC)
   ) port_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .live(tod),
      .rd_data(rd_data), .adj_word(adj_word),
      .load(load), .load_sec(load_sec), .load_ns(load_ns),
      .res_wr(res_wr), .res_data(res_data)
   );

   ptp_rate_accum #(.ADJ_EN(ADJ_EN)) accum_i (
      .frac_q(tod.frac), .adj_word(adj_word),
      .frac_nxt(frac_nxt), .carry(carry), .borrow(borrow)
   );

   ptp_time_core #(.NOM_INC_NS(NOM_INC_NS), .NS_PER_SEC(NS_PER_SEC)) core_i (
      .clk(clk), .rst_n(rst_n),
      .carry(carry), .borrow(borrow), .frac_nxt(frac_nxt),
      .load(load), .load_sec(load_sec), .load_ns(load_ns),
      .res_wr(res_wr), .res_data(res_data),
      .tod(tod), .sec_wrap(sec_wrap)
   );

   assign tod_sec = tod.sec;
   assign tod_ns  = tod.ns;
endmodule

// File: tb/ptp_tod_clock_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_clock_tb_top;
   localparam logic [3:0] A_RES = 4'h0;
   localparam logic [3:0] A_NS  = 4'h4;
   localparam logic [3:0] A_SEC = 4'h8;
   localparam logic [3:0] A_ADJ = 4'hC;
   localparam int NV = 6;

   localparam logic [31:0] V_ADJ  [NV] = '{32'h0, 32'h4000_0000, 32'hC000_0000,
                                           32'h1, 32'h7FFF_FFFF, 32'h8000_0001};
   localparam int          V_CYC  [NV] = '{100, 8, 8, 16, 4, 3};
   localparam logic [31:0] V_NS   [NV] = '{800, 66, 62, 128, 33, 23};
   localparam logic [31:0] V_FRAC [NV] = '{32'h0, 32'h0, 32'h0, 32'h10,
                                           32'hFFFF_FFFC, 32'hFFFF_FFFD};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data, tod_sec, tod_ns;
   logic        sec_wrap;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   ptp_tod_clock dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .tod_sec(tod_sec), .tod_ns(tod_ns), .sec_wrap(sec_wrap)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] q);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      q = rd_data;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=below 20000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      logic [31:0] q, ns0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 sec", tod_sec, 32'h0);
      chk("R1 ns", tod_ns, 32'h0);
      chk("R1 wrap", {31'b0, sec_wrap}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: first free-running step
      chk("R2 first step", tod_ns, 32'd8);
      rd(A_ADJ, q);
      chk("R1 adjust", q, 32'h0);
      rd(A_RES, q);
      chk("R1 residue", q, 32'h0);

      // R2 R3 R4 R7 R8: vector table
      for (int i = 0; i < NV; i++) begin
         wr(A_ADJ, V_ADJ[i]);
         wr(A_NS, 32'd0);
         wr(A_SEC, 32'(i + 3));
         repeat (V_CYC[i]) @(negedge clk);
         rd(A_RES, q);
         chk($sformatf("R3 R4 vec%0d residue", i), q, V_FRAC[i]);
         repeat (5) @(negedge clk);
         rd(A_NS, q);
         chk($sformatf("R7 vec%0d ns", i), q, V_NS[i]);
         rd(A_SEC, q);
         chk($sformatf("R8 vec%0d sec", i), q, 32'(i + 3));
      end

      // R11: adjust readback
      wr(A_ADJ, 32'h8000_1234);
      rd(A_ADJ, q);
      chk("R11 adjust readback", q, 32'h8000_1234);
      wr(A_ADJ, 32'h0);

      // R5: nanosecond wrap
      wr(A_NS, 32'd999_999_992);
      wr(A_SEC, 32'd5);
      chk("R8 loaded ns", tod_ns, 32'd999_999_992);
      chk("R8 loaded sec", tod_sec, 32'd5);
      @(negedge clk);
      chk("R5 exact wrap ns", tod_ns, 32'd0);
      chk("R5 exact wrap sec", tod_sec, 32'd6);
      wr(A_NS, 32'd999_999_995);
      wr(A_SEC, 32'd5);
      @(negedge clk);
      chk("R5 over wrap ns", tod_ns, 32'd3);
      chk("R5 over wrap sec", tod_sec, 32'd6);

      // R6: seconds rollover pulse
      wr(A_NS, 32'd999_999_992);
      wr(A_SEC, 32'hFFFF_FFFF);
      chk("R6 no pulse on load", {31'b0, sec_wrap}, 32'h0);
      @(negedge clk);
      chk("R6 sec rolled", tod_sec, 32'h0);
      chk("R6 pulse high", {31'b0, sec_wrap}, 32'h1);
      @(negedge clk);
      chk("R6 pulse low", {31'b0, sec_wrap}, 32'h0);
      chk("R6 ns after", tod_ns, 32'd8);

      // R9: illegal nanoseconds write ignored
      wr(A_NS, 32'd100);
      wr(A_SEC, 32'd1);
      wr(A_NS, 32'd1_000_000_000);
      wr(A_NS, 32'hFFFF_FFFF);
      wr(A_SEC, 32'd2);
      chk("R9 pending kept", tod_ns, 32'd100);
      chk("R9 sec loaded", tod_sec, 32'd2);

      // R10: residue write feeds next carry
      wr(A_ADJ, 32'd8);
      wr(A_NS, 32'd100);
      wr(A_SEC, 32'd1);
      wr(A_RES, 32'hFFFF_FFF8);
      chk("R10 step during write", tod_ns, 32'd108);
      @(negedge clk);
      chk("R10 carry from written residue", tod_ns, 32'd117);
      wr(A_ADJ, 32'h0);

      // R12: snapshot and load at the same edge
      wr(A_NS, 32'd1000);
      wr(A_SEC, 32'd7);
      repeat (2) @(negedge clk);
      ns0 = tod_ns;
      chk("R12 pre ns", ns0, 32'd1016);
      wr_en = 1'b1; wr_addr = A_SEC; wr_data = 32'd9;
      rd_en = 1'b1; rd_addr = A_RES;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R12 residue", rd_data, 32'h0);
      chk("R12 live sec", tod_sec, 32'd9);
      chk("R12 live ns", tod_ns, 32'd1000);
      rd(A_NS, q);
      chk("R12 snap ns", q, 32'd1016);
      rd(A_SEC, q);
      chk("R12 snap sec", q, 32'd7);

      finish_run();
   end
endmodule